// File: doc/BRIEF.md
# SPI Slave Register Access Port

This block sits behind a four-wire SPI slave and converts each chip-select frame into work for the chip. A frame opens with an opcode byte and a 16-bit address. The address is followed by data bytes. An ordinary address becomes one access on an internal 32-bit request/acknowledge register bus. Two reserved addresses instead open a byte stream: one stream feeds a transmit FIFO port and the other drains a receive FIFO port. These streams run until chip select rises.

The port also contains one read-only identification register. While the chip is still coming out of reset, a read of this register returns zero. After a programmable settling time it returns a fixed pattern. Host software polls this register to learn when the serial link can be trusted.

The SPI pins are treated as asynchronous inputs. They are synchronised into the system clock domain, and SCK edges are detected there. The system clock must therefore run several times faster than SCK.

Top module: `spi_regport`

## Requirements
- R1: SPI mode 0. MOSI is captured on the rising SCK edge, and MISO moves after the falling edge. Every byte travels most significant bit first. MISO is 0 while chip select is high.
- R2: Opcode 0x03 selects read and 0x02 selects write. Any other opcode makes the rest of the frame inert: no bus request, no FIFO push or pop, and MISO stays 0 until chip select rises.
- R3: The two bytes after the opcode form the 16-bit address, high byte first.
- R4: A register write takes four data bytes, least significant first. It issues exactly one bus write (bus_we = 1) carrying that word once the fourth byte is complete. Bytes after the fourth are ignored.
- R5: A register read issues one bus read (bus_we = 0) once the second address byte is complete. The returned word is shifted out as four bytes, least significant first. Any further bytes in that frame read as 0x00.
- R6: Once raised, bus_req stays high with bus_addr, bus_we and bus_wdata unchanged until the cycle in which bus_ack is high.
- R7: A write to TXF_ADDR packs every four consecutive data bytes, little-endian, into one word and pulses txf_push with it. A final group of fewer than four bytes is dropped.
- R8: A read from RXF_ADDR shifts out the word at rxf_data, least significant byte first. It pulses rxf_pop after the fourth byte of each word has been loaded, for any number of words per frame.
- R9: A read of TEST_ADDR never reaches the bus. It returns 0 if the access starts within READY_CYCLES clocks of reset and TEST_PATTERN afterwards. Writes to TEST_ADDR have no effect and produce no bus access.
- R10: A byte cut short by chip select rising is discarded. A register write frame that ends before four whole data bytes produces no bus write, and the next frame decodes normally.
- R11: During reset bus_req, txf_push and rxf_pop are low and spi_miso is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the master |
| spi_cs_n | input | 1 | Active-low chip select framing one transaction |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| bus_req | output | 1 | Register bus request, held until acknowledged |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 16 | Register bus address |
| bus_wdata | output | 32 | Register bus write data |
| bus_rdata | input | 32 | Register bus read data, valid with bus_ack |
| bus_ack | input | 1 | Register bus acknowledge |
| txf_push | output | 1 | One-cycle pulse: txf_data holds a packed word |
| txf_data | output | 32 | Word for the transmit FIFO |
| rxf_pop | output | 1 | One-cycle pulse: consume the head of the receive FIFO |
| rxf_data | input | 32 | Head word of the receive FIFO (show-ahead) |

## Verification
The bench builds the block with READY_CYCLES = 400, two synchroniser stages and the default addresses. The short settling time puts a zero-returning identification read and a pattern-returning read within one short run. The master holds each SCK phase for six system clocks, so an acknowledge that arrives one cycle after the request lands inside the half-period the read path allows. A read-back source with sequential byte values makes any byte-order or pop-timing slip in the streaming path visible at MISO.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

  localparam int WORD_BYTES = 4;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INSTR,
    ST_ADDR_HI,
    ST_ADDR_LO,
    ST_DATA,
    ST_DROP
  } txn_state_e;

  // Little-endian byte lane select
  function automatic logic [7:0] word_byte(input logic [31:0] w, input logic [1:0] idx);
    return w[idx*8 +: 8];
  endfunction

  // Little-endian byte lane insert
  function automatic logic [31:0] word_put(input logic [31:0] w, input logic [1:0] idx,
                                           input logic [7:0] b);
    logic [31:0] r;
    r = w;
    r[idx*8 +: 8] = b;
    return r;
  endfunction

endpackage

// File: rtl/spi_regport_pins.sv
module spi_regport_pins #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sck,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_active,
  output logic mosi_bit
);
  localparam int CW = 3 * SYNC_STAGES;

  logic [CW-1:0] chain;
  logic [2:0]    synced;
  logic          sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= {SYNC_STAGES{3'b010}};
      sck_q <= 1'b0;
    end else begin
      chain <= {chain[CW-4:0], spi_sck, spi_cs_n, spi_mosi};
      sck_q <= synced[2];
    end
  end

  assign synced    = chain[CW-1 -: 3];
  assign cs_active = ~synced[1];
  assign mosi_bit  = synced[0];
  assign sck_rise  = cs_active &  synced[2] & ~sck_q;
  assign sck_fall  = cs_active & ~synced[2] &  sck_q;

endmodule

// File: rtl/spi_regport_shifter.sv
module spi_regport_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck_rise,
  input  logic       sck_fall,
  input  logic       cs_active,
  input  logic       mosi_bit,
  input  logic [7:0] load_byte,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic       load_slot,
  output logic       spi_miso
);
  logic [2:0] bit_cnt;
  logic [6:0] sr_in;
  logic [7:0] sr_out;

  // Falling edge at a byte boundary: next outgoing byte is taken here
  assign load_slot = sck_fall && (bit_cnt == 3'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      sr_in     <= '0;
      sr_out    <= '0;
      byte_done <= 1'b0;
      rx_byte   <= '0;
    end else begin
      byte_done <= 1'b0;
      if (!cs_active) begin
        bit_cnt <= '0;   // partial byte dropped (R10)
        sr_out  <= '0;
      end else begin
        if (sck_rise) begin
          sr_in   <= {sr_in[5:0], mosi_bit};
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            byte_done <= 1'b1;
            rx_byte   <= {sr_in, mosi_bit};
          end
        end
        if (sck_fall) begin
          sr_out <= load_slot ? load_byte : {sr_out[6:0], 1'b0};
        end
      end
    end
  end

  assign spi_miso = cs_active & sr_out[7];

  // R1: a completed byte always follows a captured rising edge
  p_byte_on_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> $past(sck_rise));

  // R10: deselection clears the bit position
  p_cs_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_active |=> (bit_cnt == 3'd0) && !byte_done);

endmodule

// File: rtl/spi_regport_ready.sv
module spi_regport_ready #(
  parameter int READY_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  output logic ready
);
  localparam int CW = $clog2(READY_CYCLES + 2);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else if (!ready) begin
      if (cnt == CW'(READY_CYCLES)) ready <= 1'b1;
      else                          cnt   <= cnt + 1'b1;
    end
  end

  // R9: once functional, stays functional
  p_ready_stays_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

endmodule

// File: rtl/spi_regport_ctrl.sv
module spi_regport_ctrl
  import spi_regport_pkg::*;
#(
  parameter logic [15:0] RXF_ADDR     = 16'h0100,
  parameter logic [15:0] TXF_ADDR     = 16'h0104,
  parameter logic [15:0] TEST_ADDR    = 16'h0050,
  parameter logic [31:0] TEST_PATTERN = 32'hA5C3_1E0F
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_active,
  input  logic        byte_done,
  input  logic [7:0]  rx_byte,
  input  logic        load_slot,
  input  logic        test_ready,
  output logic [7:0]  load_byte,
  output logic        bus_req,
  output logic        bus_we,
  output logic [15:0] bus_addr,
  output logic [31:0] bus_wdata,
  input  logic [31:0] bus_rdata,
  input  logic        bus_ack,
  output logic        txf_push,
  output logic [31:0] txf_data,
  input  logic [31:0] rxf_data,
  output logic        rxf_pop
);
  localparam logic [1:0] LAST_LANE = 2'(WORD_BYTES - 1);

  txn_state_e  state;
  logic        op_rd, is_fifo, rd_spent, wr_spent;
  logic [7:0]  addr_hi;
  logic [15:0] addr;
  logic [31:0] wr_word, rd_word;
  logic [1:0]  rx_idx, ld_idx;

  // Named internal events
  logic [15:0] full_addr;
  logic        addr_done, word_done, read_load, handshake;
  logic [31:0] word_next;

  assign full_addr = {addr_hi, rx_byte};
  assign addr_done = byte_done && (state == ST_ADDR_LO);
  assign word_done = byte_done && (state == ST_DATA) && !op_rd && (rx_idx == LAST_LANE);
  assign read_load = load_slot && (state == ST_DATA) && op_rd;
  assign handshake = bus_req && bus_ack;
  assign word_next = word_put(wr_word, rx_idx, rx_byte);

  always_comb begin
    load_byte = 8'h00;
    if ((state == ST_DATA) && op_rd) begin
      if (is_fifo)        load_byte = word_byte(rxf_data, ld_idx);
      else if (!rd_spent) load_byte = word_byte(rd_word, ld_idx);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      op_rd     <= 1'b0;
      is_fifo   <= 1'b0;
      rd_spent  <= 1'b0;
      wr_spent  <= 1'b0;
      addr_hi   <= '0;
      addr      <= '0;
      wr_word   <= '0;
      rd_word   <= '0;
      rx_idx    <= '0;
      ld_idx    <= '0;
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      txf_push  <= 1'b0;
      txf_data  <= '0;
      rxf_pop   <= 1'b0;
    end else begin
      txf_push <= 1'b0;
      rxf_pop  <= 1'b0;
      if (handshake) begin
        bus_req <= 1'b0;
        if (!bus_we) rd_word <= bus_rdata;
      end
      if (!cs_active) begin
        state <= ST_IDLE;
      end else begin
        unique case (state)
          ST_IDLE: state <= ST_INSTR;
          ST_INSTR: if (byte_done) begin
            if (rx_byte == OP_READ) begin
              op_rd <= 1'b1;
              state <= ST_ADDR_HI;
            end else if (rx_byte == OP_WRITE) begin
              op_rd <= 1'b0;
              state <= ST_ADDR_HI;
            end else begin
              state <= ST_DROP;
            end
          end
          ST_ADDR_HI: if (byte_done) begin
            addr_hi <= rx_byte;
            state   <= ST_ADDR_LO;
          end
          ST_ADDR_LO: if (addr_done) begin
            addr     <= full_addr;
            state    <= ST_DATA;
            rx_idx   <= '0;
            ld_idx   <= '0;
            rd_spent <= 1'b0;
            wr_spent <= 1'b0;
            is_fifo  <= op_rd ? (full_addr == RXF_ADDR) : (full_addr == TXF_ADDR);
            if (op_rd && (full_addr != RXF_ADDR)) begin
              if (full_addr == TEST_ADDR) begin
                rd_word <= test_ready ? TEST_PATTERN : 32'h0;
              end else begin
                bus_req  <= 1'b1;
                bus_we   <= 1'b0;
                bus_addr <= full_addr;
              end
            end
          end
          ST_DATA: begin
            if (byte_done && !op_rd) begin
              wr_word <= word_next;
              rx_idx  <= rx_idx + 2'd1;
            end
            if (word_done) begin
              if (is_fifo) begin
                txf_push <= 1'b1;
                txf_data <= word_next;
              end else if (!wr_spent) begin
                wr_spent <= 1'b1;
                if (addr != TEST_ADDR) begin
                  bus_req   <= 1'b1;
                  bus_we    <= 1'b1;
                  bus_addr  <= addr;
                  bus_wdata <= word_next;
                end
              end
            end
            if (read_load) begin
              ld_idx <= ld_idx + 2'd1;
              if (ld_idx == LAST_LANE) begin
                if (is_fifo) rxf_pop  <= 1'b1;
                else         rd_spent <= 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R6: request held steady until acknowledged
  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

  // R2: an unknown opcode produces no activity
  p_drop_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DROP) |=> !txf_push && !rxf_pop && !$rose(bus_req));

  // R7: pushes only follow a completed data byte
  p_push_on_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
    txf_push |-> $past(byte_done) && ($past(state) == ST_DATA));

  // R8: pops only follow a byte load
  p_pop_on_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rxf_pop |-> $past(load_slot));

  // R10: a bus write only starts on a completed byte
  p_write_on_byte_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) && bus_we |-> $past(byte_done));

endmodule

// File: rtl/spi_regport.sv
module spi_regport #(
  parameter int          SYNC_STAGES  = 2,
  parameter int          READY_CYCLES = 1000,
  parameter logic [15:0] RXF_ADDR     = 16'h0100,
  parameter logic [15:0] TXF_ADDR     = 16'h0104,
  parameter logic [15:0] TEST_ADDR    = 16'h0050,
  parameter logic [31:0] TEST_PATTERN = 32'hA5C3_1E0F
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        spi_sck,
  input  logic        spi_cs_n,
  input  logic        spi_mosi,
  output logic        spi_miso,
  output logic        bus_req,
  output logic        bus_we,
  output logic [15:0] bus_addr,
  output logic [31:0] bus_wdata,
  input  logic [31:0] bus_rdata,
  input  logic        bus_ack,
  output logic        txf_push,
  output logic [31:0] txf_data,
  output logic        rxf_pop,
  input  logic [31:0] rxf_data
);
  logic       sck_rise, sck_fall, cs_active, mosi_bit;
  logic       byte_done, load_slot, test_ready;
  logic [7:0] rx_byte, load_byte;

  spi_regport_pins #(.SYNC_STAGES(SYNC_STAGES)) u_pins (
    .clk, .rst_n, .spi_sck, .spi_cs_n, .spi_mosi,
    .sck_rise, .sck_fall, .cs_active, .mosi_bit
  );

  spi_regport_shifter u_shift (
    .clk, .rst_n, .sck_rise, .sck_fall, .cs_active, .mosi_bit,
    .load_byte, .byte_done, .rx_byte, .load_slot, .spi_miso
  );

  spi_regport_ready #(.READY_CYCLES(READY_CYCLES)) u_ready (
    .clk, .rst_n, .ready(test_ready)
  );

  spi_regport_ctrl #(
    .RXF_ADDR(RXF_ADDR), .TXF_ADDR(TXF_ADDR),
    .TEST_ADDR(TEST_ADDR), .TEST_PATTERN(TEST_PATTERN)
  ) u_ctrl (
    .clk, .rst_n, .cs_active, .byte_done, .rx_byte, .load_slot, .test_ready,
    .load_byte, .bus_req, .bus_we, .bus_addr, .bus_wdata, .bus_rdata, .bus_ack,
    .txf_push, .txf_data, .rxf_data, .rxf_pop
  );

  // R11: nothing moves during reset
  always_comb begin
    if (!rst_n) begin
      a_reset_quiet_r11: assert (!bus_req && !txf_push && !rxf_pop && !spi_miso);
    end
  end

endmodule

// File: tb/spi_regport_tb_top.sv
module spi_regport_tb_top;
  localparam int          HP     = 6;
  localparam int          READY  = 400;
  localparam logic [15:0] RXA    = 16'h0100;
  localparam logic [15:0] TXA    = 16'h0104;
  localparam logic [15:0] TSTA   = 16'h0050;
  localparam logic [31:0] PAT    = 32'hA5C3_1E0F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, miso;
  logic bus_req, bus_we, bus_ack, txf_push, rxf_pop;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata, txf_data, rxf_data;

  spi_regport #(.READY_CYCLES(READY)) dut_i (
    .clk, .rst_n, .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso),
    .bus_req, .bus_we, .bus_addr, .bus_wdata, .bus_rdata, .bus_ack,
    .txf_push, .txf_data, .rxf_pop, .rxf_data
  );

  int checks = 0, fails = 0, hold_bad = 0;
  bit done = 1'b0;

  typedef struct packed { logic [1:0] kind; logic [15:0] addr; logic [31:0] data; } item_t;
  item_t exp_q[$];

  logic [7:0] tb_tx [0:15];
  logic [7:0] tb_rx [0:15];

  // Register bus responder: acknowledges one cycle after a request
  always @(posedge clk) begin
    if (!rst_n) begin
      bus_ack   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ack   <= bus_req && !bus_ack;
      bus_rdata <= {bus_addr, ~bus_addr};
    end
  end

  // Receive FIFO source: byte stream 0,1,2,...
  logic [31:0] rx_mem [0:7];
  int rx_head = 0;
  initial for (int i = 0; i < 8; i++)
    rx_mem[i] = {8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)};
  assign rxf_data = rx_mem[rx_head[2:0]];
  always @(posedge clk) if (rst_n && rxf_pop) rx_head <= rx_head + 1;

  task automatic check(input string req, input logic [49:0] act, input logic [49:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic mon_item(input item_t got, input string req);
    item_t e;
    if (exp_q.size() == 0) begin
      checks++; fails++;
      $display("FAIL %s unexpected item actual=%h expected=none", req, got);
    end else begin
      e = exp_q.pop_front();
      check(req, got, e);
    end
  endtask

  // Scoreboard monitor, sampled away from the active edge
  logic        req_q = 1'b0, ack_q = 1'b0, we_q = 1'b0;
  logic [15:0] addr_q = '0;
  logic [31:0] wd_q = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_req && bus_ack)
        mon_item({bus_we ? 2'd0 : 2'd1, bus_addr, bus_we ? bus_wdata : 32'h0}, "bus access R4 R5");
      if (txf_push) mon_item({2'd2, 16'h0, txf_data}, "tx push R7");
      if (req_q && !ack_q &&
          (!bus_req || bus_addr != addr_q || bus_we != we_q || bus_wdata != wd_q)) hold_bad++;
      req_q <= bus_req; ack_q <= bus_ack; addr_q <= bus_addr; we_q <= bus_we; wd_q <= bus_wdata;
    end
  end

  task automatic spi_frame(input int nbytes, input int extra_bits);
    cs_n = 1'b0;
    repeat (HP) @(negedge clk);
    for (int i = 0; i < nbytes; i++) begin
      for (int b = 7; b >= 0; b--) begin
        mosi = tb_tx[i][b];
        repeat (HP) @(negedge clk);
        sck = 1'b1;
        tb_rx[i][b] = miso;
        repeat (HP) @(negedge clk);
        sck = 1'b0;
      end
    end
    for (int b = 0; b < extra_bits; b++) begin
      mosi = 1'b1;
      repeat (HP) @(negedge clk);
      sck = 1'b1;
      repeat (HP) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HP) @(negedge clk);
    cs_n = 1'b1;
    mosi = 1'b0;
    repeat (4*HP) @(negedge clk);
  endtask

  task automatic set_hdr(input logic [7:0] op, input logic [15:0] a);
    for (int i = 0; i < 16; i++) tb_tx[i] = 8'h00;
    tb_tx[0] = op; tb_tx[1] = a[15:8]; tb_tx[2] = a[7:0];
  endtask

  function automatic logic [31:0] rx_word(input int first);
    return {tb_rx[first+3], tb_rx[first+2], tb_rx[first+1], tb_rx[first]};
  endfunction

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    repeat (5) @(negedge clk);
    // R11: reset state
    check("R11 reset outputs", {46'h0, bus_req, txf_push, rxf_pop, miso}, 50'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R9: identification read before the settling time returns zero
    set_hdr(8'h03, TSTA);
    spi_frame(7, 0);
    check("R9 early test read", rx_word(3), 32'h0);

    // R9: after settling it returns the pattern (R1 bit order within bytes)
    set_hdr(8'h03, TSTA);
    spi_frame(7, 0);
    check("R9 R1 test pattern", rx_word(3), PAT);

    // R9: writes to the test register are ignored and reach no bus
    set_hdr(8'h02, TSTA);
    tb_tx[3] = 8'h11; tb_tx[4] = 8'h22; tb_tx[5] = 8'h33; tb_tx[6] = 8'h44;
    spi_frame(7, 0);
    set_hdr(8'h03, TSTA);
    spi_frame(7, 0);
    check("R9 test reg after write", rx_word(3), PAT);
    check("R9 no bus access", exp_q.size(), 0);

    // R4 R3: register write, extra bytes ignored
    exp_q.push_back({2'd0, 16'h1234, 32'hDEADBEEF});
    set_hdr(8'h02, 16'h1234);
    tb_tx[3] = 8'hEF; tb_tx[4] = 8'hBE; tb_tx[5] = 8'hAD; tb_tx[6] = 8'hDE;
    tb_tx[7] = 8'h55; tb_tx[8] = 8'h66;
    spi_frame(9, 0);
    check("R4 R3 single write drained", exp_q.size(), 0);

    // R5 R1: register read, trailing bytes zero
    exp_q.push_back({2'd1, 16'h0A0C, 32'h0});
    set_hdr(8'h03, 16'h0A0C);
    spi_frame(9, 0);
    check("R1 miso quiet in header", {tb_rx[0], tb_rx[1], tb_rx[2]}, 24'h0);
    check("R5 R1 read data", rx_word(3), {16'h0A0C, 16'hF5F3});
    check("R5 trailing zero", {tb_rx[7], tb_rx[8]}, 16'h0);
    check("R5 single read drained", exp_q.size(), 0);

    // R2: unknown opcode
    set_hdr(8'h0B, TXA);
    tb_tx[3] = 8'hAA; tb_tx[4] = 8'hBB; tb_tx[5] = 8'hCC; tb_tx[6] = 8'hDD;
    spi_frame(7, 0);
    check("R2 miso quiet", rx_word(3), 32'h0);
    check("R2 no activity", {exp_q.size(), rx_head}, {32'h0, 32'h0});

    // R7: transmit stream, 8 bytes plus a 3-byte tail
    exp_q.push_back({2'd2, 16'h0, 32'h030201D0});
    exp_q.push_back({2'd2, 16'h0, 32'h07060504});
    set_hdr(8'h02, TXA);
    tb_tx[3] = 8'hD0;
    for (int i = 1; i < 11; i++) tb_tx[3+i] = 8'(i);
    spi_frame(14, 0);
    check("R7 stream pushes drained", exp_q.size(), 0);

    // R8: receive stream of three words
    set_hdr(8'h03, RXA);
    spi_frame(15, 0);
    check("R8 word 0", rx_word(3), 32'h03020100);
    check("R8 word 1", rx_word(7), 32'h07060504);
    check("R8 word 2", rx_word(11), 32'h0B0A0908);
    check("R8 pop count", rx_head, 3);

    // R10: write cut short, partial byte discarded
    set_hdr(8'h02, 16'h2222);
    tb_tx[3] = 8'h01; tb_tx[4] = 8'h02; tb_tx[5] = 8'h03;
    spi_frame(6, 5);
    check("R10 no write from short frame", exp_q.size(), 0);
    exp_q.push_back({2'd0, 16'h2222, 32'h44332211});
    set_hdr(8'h02, 16'h2222);
    tb_tx[3] = 8'h11; tb_tx[4] = 8'h22; tb_tx[5] = 8'h33; tb_tx[6] = 8'h44;
    spi_frame(7, 0);
    check("R10 next frame decodes", exp_q.size(), 0);

    // R6: request stability observed across the run
    check("R6 request hold violations", hold_bad, 0);

    report();
  end

endmodule